// File: doc/BRIEF.md
# Quad DAC SPI Register Interface

This block is the slave-side digital front end of a four-channel digital-to-analog converter. A host sends it 24-bit SPI frames. Each frame either writes one register or asks for one register to be read. Write frames update per-channel output codes, gain and offset trims, and a set of control sub-registers. The current contents of all of these leave the block on parallel ports, where the analog stage and the slew engine pick them up.

Reads are split over two frames. The first frame names the register. The reply is shifted out on MISO during the next frame, which the host normally fills with a fixed no-op word. The SPI pins are oversampled in the system clock domain, and a frame takes effect only when chip select is released after exactly 24 bits.

Top module: `qdac_spi_regif`

## Requirements
- R1: A frame is MSB first, SPI mode 0: MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge. Frame bit 23 set means a read request. Bits 20:16 hold the register address, bits 15:0 hold the write data, and bits 22:21 are ignored.
- R2: A write to address ch (0..3) sets that channel's output code. A write to 0x08|ch sets its gain, and a write to 0x10|ch sets its offset. Each takes all 16 data bits.
- R3: A write to 0x1C|ch picks a control sub-register with data bits 15:13. Value 0 loads the channel's slew field from bits 12:0. Value 2 loads the channel's DAC control from bits 8:0. Value 1 loads the shared main field from bits 12:0. Value 3 loads the shared DC-DC field from bits 6:0. Values 4 to 7 change no register.
- R4: DAC control bit layout, as it appears on `dac_ctrl`: 2:0 range mode, 3 voltage overrange, 4 DC-DC enable, 5 internal sense resistor, 6 output enable, 7 clear enable, 8 internal enable. DC-DC layout: 1:0 maximum voltage, 3:2 switching frequency, 5:4 phase, 6 external compensation resistor. The status read returns each channel's output-enable bit at bit position ch.
- R5: Read addresses: ch is the code, 0x04|ch the DAC control, 0x08|ch the gain, 0x0C|ch the offset, 0x14|ch the slew field, 0x18 status, 0x19 main and 0x1A DC-DC. The clear addresses 0x10|ch and every other address read as zero.
- R6: After a complete read frame, the next frame shifts out 8 zero bits and then the 16-bit value, MSB first. A frame that does not follow a complete read shifts out zeros. A read frame changes no register.
- R7: The no-op frame 0x1CE000 changes no register.
- R8: MISO is driven, with `spi_miso_oe` high, only while the synchronized chip select is low. While undriven, `spi_miso` is 0.
- R9: Synchronous reset sets every gain to 0xFFFF and every offset to 0x8000. It clears all other registers and any pending reply.
- R10: A write to any address not listed in R2 or R3 changes no register.
- R11: A frame that ends with a bit count other than 24 neither writes nor requests a read. It still uses up a pending reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, asynchronous |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| dac_code | output | NCH*16 | Output code per channel, channel 0 in the low bits |
| dac_gain | output | NCH*16 | Gain trim per channel |
| dac_offset | output | NCH*16 | Offset trim per channel |
| dac_ctrl | output | NCH*9 | DAC control field per channel (R4 layout) |
| slew_cfg | output | NCH*13 | Slew configuration per channel for the slew engine |
| main_cfg | output | 13 | Shared main control field |
| dcdc_cfg | output | 7 | Shared DC-DC field (R4 layout) |

## Verification
The hardest state to reach is the pending reply. It exists only between a read frame and the next frame, so what it holds depends on the order of frames rather than on any single one. The stimulus chains read after read, follows reads with writes, with aborted frames of 23 or 25 bits, and with unmapped or no-op frames. It then checks that each reply carries the value captured when its request was committed and that an aborted frame still uses that reply up. A bench model tracks the pending reply across all of these orders.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int FRAME_W = 24;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int CH_W    = 2;
    localparam int SUB_W   = 3;
    localparam int DACC_W  = 9;
    localparam int SLEW_W  = 13;
    localparam int MAIN_W  = 13;
    localparam int DCDC_W  = 7;
    localparam int PAD_W   = FRAME_W - WORD_W;

    // Bit of the DAC control field that enables the output (reported in status)
    localparam int DACC_OUT_EN = 6;

    localparam logic [WORD_W-1:0]  GAIN_RST  = 16'hFFFF;
    localparam logic [WORD_W-1:0]  OFFS_RST  = 16'h8000;
    localparam logic [FRAME_W-1:0] NOOP_WORD = 24'h1CE000;

    // Control sub-register selectors (data bits 15:13)
    localparam logic [SUB_W-1:0] SUB_SLEW = 3'd0;
    localparam logic [SUB_W-1:0] SUB_MAIN = 3'd1;
    localparam logic [SUB_W-1:0] SUB_DACC = 3'd2;
    localparam logic [SUB_W-1:0] SUB_DCDC = 3'd3;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_CODE,
        WK_GAIN,
        WK_OFFS,
        WK_CTRL
    } wkind_e;

    typedef enum logic [3:0] {
        RK_ZERO,
        RK_CODE,
        RK_CTRL,
        RK_GAIN,
        RK_OFFS,
        RK_SLEW,
        RK_STAT,
        RK_MAIN,
        RK_DCDC
    } rkind_e;

    typedef struct packed {
        logic              rd;
        logic [1:0]        rsvd;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } frame_t;

    typedef struct packed {
        wkind_e            kind;
        logic [CH_W-1:0]   ch;
        logic [SUB_W-1:0]  sub;
        logic [WORD_W-1:0] data;
    } wr_op_t;

    typedef struct packed {
        rkind_e          kind;
        logic [CH_W-1:0] ch;
        logic            per_ch;
    } rd_op_t;

    function automatic wr_op_t decode_wr(input logic [ADDR_W-1:0] a,
                                         input logic [WORD_W-1:0] d);
        wr_op_t w;
        w.ch   = a[CH_W-1:0];
        w.sub  = d[WORD_W-1 -: SUB_W];
        w.data = d;
        case (a[ADDR_W-1:CH_W])
            3'b000:  w.kind = WK_CODE;
            3'b010:  w.kind = WK_GAIN;
            3'b100:  w.kind = WK_OFFS;
            3'b111:  w.kind = WK_CTRL;
            default: w.kind = WK_NONE;
        endcase
        return w;
    endfunction

    function automatic rd_op_t decode_rd(input logic [ADDR_W-1:0] a);
        rd_op_t r;
        r.ch     = a[CH_W-1:0];
        r.per_ch = 1'b1;
        case (a[ADDR_W-1:CH_W])
            3'b000:  r.kind = RK_CODE;
            3'b001:  r.kind = RK_CTRL;
            3'b010:  r.kind = RK_GAIN;
            3'b011:  r.kind = RK_OFFS;
            3'b101:  r.kind = RK_SLEW;
            3'b110: begin
                r.per_ch = 1'b0;
                case (a[CH_W-1:0])
                    2'd0:    r.kind = RK_STAT;
                    2'd1:    r.kind = RK_MAIN;
                    2'd2:    r.kind = RK_DCDC;
                    default: r.kind = RK_ZERO;
                endcase
            end
            default: r.kind = RK_ZERO;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qdac_spi_frontend.sv
module qdac_spi_frontend
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               spi_miso,
    output logic               spi_miso_oe,
    output logic               frame_start,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_word
);

    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [SYNC_STAGES-1:0] cs_pipe;
    logic [SYNC_STAGES-1:0] sclk_pipe;
    logic [SYNC_STAGES-1:0] mosi_pipe;
    logic cs_s, sclk_s, mosi_s;
    logic cs_d, sclk_d;
    logic cs_fall, cs_rise, sclk_rise, sclk_fall, active;

    logic [FRAME_W-1:0] rx_sh;
    logic [FRAME_W-1:0] tx_sh;
    logic [CNT_W-1:0]   bit_cnt;

    // Pin synchronizers into the system clock domain
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_pipe   <= '1;
            sclk_pipe <= '0;
            mosi_pipe <= '0;
            cs_d      <= 1'b1;
            sclk_d    <= 1'b0;
        end else begin
            cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], spi_cs_n};
            sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], spi_sclk};
            mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], spi_mosi};
            cs_d      <= cs_s;
            sclk_d    <= sclk_s;
        end
    end

    assign cs_s      = cs_pipe[SYNC_STAGES-1];
    assign sclk_s    = sclk_pipe[SYNC_STAGES-1];
    assign mosi_s    = mosi_pipe[SYNC_STAGES-1];
    assign active    = ~cs_s;
    assign cs_fall   = cs_d & ~cs_s;
    assign cs_rise   = ~cs_d & cs_s;
    assign sclk_rise = ~sclk_d & sclk_s;
    assign sclk_fall = sclk_d & ~sclk_s;

    // Shift registers, bit counter and frame commit
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh      <= '0;
            tx_sh      <= '0;
            bit_cnt    <= '0;
            frame_vld  <= 1'b0;
            frame_word <= '0;
        end else begin
            frame_vld <= 1'b0;
            if (cs_fall) begin
                rx_sh   <= '0;
                tx_sh   <= tx_word;
                bit_cnt <= '0;
            end else if (active && sclk_rise) begin
                rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
                if (bit_cnt != CNT_MAX) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (active && sclk_fall) begin
                tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
            end
            if (cs_rise) begin
                frame_vld  <= (bit_cnt == CNT_FULL);
                frame_word <= rx_sh;
            end
        end
    end

    assign frame_start = cs_fall;
    assign spi_miso_oe = active;
    assign spi_miso    = active & tx_sh[FRAME_W-1];

endmodule

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
    import qdac_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [FRAME_W-1:0] frame_word,
    output logic               is_rd,
    output wr_op_t             wr,
    output rd_op_t             rd
);

    frame_t f;
    logic   unused_rsvd;

    assign f           = frame_t'(frame_word);
    assign unused_rsvd = ^f.rsvd;

    always_comb begin
        is_rd = f.rd;
        wr    = decode_wr(f.addr, f.data);
        rd    = decode_rd(f.addr);
        // Channels beyond the instantiated count behave as unmapped
        if (int'(wr.ch) >= NCH) begin
            wr.kind = WK_NONE;
        end
        if (rd.per_ch && int'(rd.ch) >= NCH) begin
            rd.kind = RK_ZERO;
        end
    end

endmodule

// File: rtl/qdac_regfile.sv
module qdac_regfile
    import qdac_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_start,
    input  logic                          frame_vld,
    input  logic                          is_rd,
    input  wr_op_t                        wr,
    input  rd_op_t                        rd,
    output logic [NCH-1:0][WORD_W-1:0]    code_q,
    output logic [NCH-1:0][WORD_W-1:0]    gain_q,
    output logic [NCH-1:0][WORD_W-1:0]    offs_q,
    output logic [NCH-1:0][DACC_W-1:0]    dacc_q,
    output logic [NCH-1:0][SLEW_W-1:0]    slew_q,
    output logic [MAIN_W-1:0]             main_q,
    output logic [DCDC_W-1:0]             dcdc_q,
    output logic [FRAME_W-1:0]            reply_word
);

    logic              wr_en, rd_en;
    logic [WORD_W-1:0] rd_val;
    logic [WORD_W-1:0] rd_buf;
    logic              rd_pend;
    logic [NCH-1:0]    oe_bits;

    assign wr_en = frame_vld & ~is_rd;
    assign rd_en = frame_vld & is_rd;

    // Per-channel register banks
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = wr_en && (wr.ch == CH_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[c] <= '0;
                gain_q[c] <= GAIN_RST;
                offs_q[c] <= OFFS_RST;
                dacc_q[c] <= '0;
                slew_q[c] <= '0;
            end else if (sel) begin
                case (wr.kind)
                    WK_CODE: code_q[c] <= wr.data;
                    WK_GAIN: gain_q[c] <= wr.data;
                    WK_OFFS: offs_q[c] <= wr.data;
                    WK_CTRL: begin
                        if (wr.sub == SUB_SLEW) slew_q[c] <= wr.data[SLEW_W-1:0];
                        if (wr.sub == SUB_DACC) dacc_q[c] <= wr.data[DACC_W-1:0];
                    end
                    default: ;
                endcase
            end
        end

        assign oe_bits[c] = dacc_q[c][DACC_OUT_EN];
    end

    // Shared control fields; the channel field of the address plays no part
    always_ff @(posedge clk) begin
        if (rst) begin
            main_q <= '0;
            dcdc_q <= '0;
        end else if (wr_en && wr.kind == WK_CTRL) begin
            if (wr.sub == SUB_MAIN) main_q <= wr.data[MAIN_W-1:0];
            if (wr.sub == SUB_DCDC) dcdc_q <= wr.data[DCDC_W-1:0];
        end
    end

    // Readback selection
    always_comb begin
        rd_val = '0;
        case (rd.kind)
            RK_CODE: rd_val = code_q[rd.ch];
            RK_CTRL: rd_val = WORD_W'(dacc_q[rd.ch]);
            RK_GAIN: rd_val = gain_q[rd.ch];
            RK_OFFS: rd_val = offs_q[rd.ch];
            RK_SLEW: rd_val = WORD_W'(slew_q[rd.ch]);
            RK_STAT: rd_val = WORD_W'(oe_bits);
            RK_MAIN: rd_val = WORD_W'(main_q);
            RK_DCDC: rd_val = WORD_W'(dcdc_q);
            default: rd_val = '0;
        endcase
    end

    // One-frame reply buffer: captured at commit, consumed by the next frame
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_buf  <= '0;
            rd_pend <= 1'b0;
        end else if (rd_en) begin
            rd_buf  <= rd_val;
            rd_pend <= 1'b1;
        end else if (frame_start) begin
            rd_pend <= 1'b0;
        end
    end

    assign reply_word = rd_pend ? {PAD_W'(0), rd_buf} : '0;

endmodule

// File: rtl/qdac_spi_regif.sv
module qdac_spi_regif
    import qdac_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spi_sclk,
    input  logic                    spi_cs_n,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic                    spi_miso_oe,
    output logic [NCH*WORD_W-1:0]   dac_code,
    output logic [NCH*WORD_W-1:0]   dac_gain,
    output logic [NCH*WORD_W-1:0]   dac_offset,
    output logic [NCH*DACC_W-1:0]   dac_ctrl,
    output logic [NCH*SLEW_W-1:0]   slew_cfg,
    output logic [MAIN_W-1:0]       main_cfg,
    output logic [DCDC_W-1:0]       dcdc_cfg
);

    logic               frame_start;
    logic               frame_vld;
    logic [FRAME_W-1:0] frame_word;
    logic [FRAME_W-1:0] reply_word;
    logic               is_rd;
    wr_op_t             wr;
    rd_op_t             rd;

    logic [NCH-1:0][WORD_W-1:0] code_q, gain_q, offs_q;
    logic [NCH-1:0][DACC_W-1:0] dacc_q;
    logic [NCH-1:0][SLEW_W-1:0] slew_q;

    qdac_spi_frontend #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk         (clk),
        .rst         (rst),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .tx_word     (reply_word),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .frame_start (frame_start),
        .frame_vld   (frame_vld),
        .frame_word  (frame_word)
    );

    qdac_cmd_decode #(
        .NCH (NCH)
    ) u_dec (
        .frame_word (frame_word),
        .is_rd      (is_rd),
        .wr         (wr),
        .rd         (rd)
    );

    qdac_regfile #(
        .NCH (NCH)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_vld   (frame_vld),
        .is_rd       (is_rd),
        .wr          (wr),
        .rd          (rd),
        .code_q      (code_q),
        .gain_q      (gain_q),
        .offs_q      (offs_q),
        .dacc_q      (dacc_q),
        .slew_q      (slew_q),
        .main_q      (main_cfg),
        .dcdc_q      (dcdc_cfg),
        .reply_word  (reply_word)
    );

    assign dac_code   = code_q;
    assign dac_gain   = gain_q;
    assign dac_offset = offs_q;
    assign dac_ctrl   = dacc_q;
    assign slew_cfg   = slew_q;

endmodule

// File: rtl/qdac_spi_regif_chk.sv
module qdac_spi_regif_chk
    import qdac_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  spi_cs_n,
    input logic                  spi_miso,
    input logic                  spi_miso_oe,
    input logic                  frame_vld,
    input logic [FRAME_W-1:0]    frame_word,
    input logic [NCH*WORD_W-1:0] dac_code,
    input logic [NCH*WORD_W-1:0] dac_gain,
    input logic [NCH*WORD_W-1:0] dac_offset,
    input logic [NCH*DACC_W-1:0] dac_ctrl,
    input logic [NCH*SLEW_W-1:0] slew_cfg,
    input logic [MAIN_W-1:0]     main_cfg,
    input logic [DCDC_W-1:0]     dcdc_cfg
);

    localparam int ALL_W = NCH * (3 * WORD_W + DACC_W + SLEW_W) + MAIN_W + DCDC_W;

    logic [ALL_W-1:0] regs_all;
    logic [3:0]       cs_hi_cnt;

    assign regs_all = {dac_code, dac_gain, dac_offset, dac_ctrl, slew_cfg, main_cfg, dcdc_cfg};

    // Consecutive cycles with chip select high at the pin
    always_ff @(posedge clk) begin
        if (rst || !spi_cs_n) begin
            cs_hi_cnt <= '0;
        end else if (cs_hi_cnt != 4'hF) begin
            cs_hi_cnt <= cs_hi_cnt + 1'b1;
        end
    end

    // R8
    miso_release_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_hi_cnt >= 4'(SYNC_STAGES)) |-> !spi_miso_oe);

    // R8
    miso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !spi_miso_oe |-> !spi_miso);

    // R11
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> $stable(regs_all));

    // R6
    read_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && frame_word[FRAME_W-1]) |=> $stable(regs_all));

    // R7
    noop_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && frame_word == NOOP_WORD) |=> $stable(regs_all));

    // R9
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (dac_gain == {NCH{GAIN_RST}} && dac_offset == {NCH{OFFS_RST}}
                 && dac_code == '0 && dac_ctrl == '0 && !spi_miso_oe));

endmodule

bind qdac_spi_regif qdac_spi_regif_chk #(
    .NCH         (NCH),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .frame_vld   (frame_vld),
    .frame_word  (frame_word),
    .dac_code    (dac_code),
    .dac_gain    (dac_gain),
    .dac_offset  (dac_offset),
    .dac_ctrl    (dac_ctrl),
    .slew_cfg    (slew_cfg),
    .main_cfg    (main_cfg),
    .dcdc_cfg    (dcdc_cfg)
);

// File: tb/qdac_spi_regif_test.sv
`timescale 1ns/1ps
module qdac_spi_regif_test;

    localparam int NCH      = 4;
    localparam int HALF     = 6;
    localparam int WD_LIMIT = 180000;
    localparam int N_RAND   = 220;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe;
    logic [NCH*16-1:0] dac_code, dac_gain, dac_offset;
    logic [NCH*9-1:0]  dac_ctrl;
    logic [NCH*13-1:0] slew_cfg;
    logic [12:0]       main_cfg;
    logic [6:0]        dcdc_cfg;

    always #2.5 clk = ~clk;

    qdac_spi_regif #(.NCH(NCH), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe),
        .dac_code(dac_code), .dac_gain(dac_gain), .dac_offset(dac_offset),
        .dac_ctrl(dac_ctrl), .slew_cfg(slew_cfg), .main_cfg(main_cfg), .dcdc_cfg(dcdc_cfg)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model
    logic [15:0] m_code [NCH];
    logic [15:0] m_gain [NCH];
    logic [15:0] m_offs [NCH];
    logic [8:0]  m_ctrl [NCH];
    logic [12:0] m_slew [NCH];
    logic [12:0] m_main;
    logic [6:0]  m_dcdc;
    logic [15:0] m_buf;
    bit          m_pend;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_code[c] = 16'h0;   m_gain[c] = 16'hFFFF; m_offs[c] = 16'h8000;
            m_ctrl[c] = 9'h0;    m_slew[c] = 13'h0;
        end
        m_main = '0; m_dcdc = '0; m_buf = '0; m_pend = 1'b0;
    endtask

    function automatic logic [15:0] model_read(input logic [4:0] a);
        logic [15:0] st;
        st = '0;
        for (int c = 0; c < NCH; c++) st[c] = m_ctrl[c][6];
        case (a[4:2])
            3'b000: return m_code[a[1:0]];
            3'b001: return 16'(m_ctrl[a[1:0]]);
            3'b010: return m_gain[a[1:0]];
            3'b011: return m_offs[a[1:0]];
            3'b101: return 16'(m_slew[a[1:0]]);
            3'b110: begin
                if (a[1:0] == 2'd0) return st;
                if (a[1:0] == 2'd1) return 16'(m_main);
                if (a[1:0] == 2'd2) return 16'(m_dcdc);
                return 16'h0;
            end
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [15:0] d);
        case (a[4:2])
            3'b000: m_code[a[1:0]] = d;
            3'b010: m_gain[a[1:0]] = d;
            3'b100: m_offs[a[1:0]] = d;
            3'b111: begin
                case (d[15:13])
                    3'd0: m_slew[a[1:0]] = d[12:0];
                    3'd1: m_main = d[12:0];
                    3'd2: m_ctrl[a[1:0]] = d[8:0];
                    3'd3: m_dcdc = d[6:0];
                    default: ;
                endcase
            end
            default: ;
        endcase
    endtask

    function automatic logic [23:0] mk(input bit rd, input logic [4:0] a, input logic [15:0] d);
        logic [1:0] junk;
        junk = 2'($urandom);
        return {rd, junk, a, d};
    endfunction

    task automatic spi_frame(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
        rx = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? tx[23-i] : 1'b0;
            wait_clk(HALF);
            rx = {rx[22:0], miso};
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(2 * HALF);
    endtask

    task automatic check_state(input string req);
        for (int c = 0; c < NCH; c++) begin
            check(dac_code[c*16 +: 16] == m_code[c], $sformatf("%s/R2 code ch%0d", req, c),
                  32'(dac_code[c*16 +: 16]), 32'(m_code[c]));
            check(dac_gain[c*16 +: 16] == m_gain[c], $sformatf("%s/R2 gain ch%0d", req, c),
                  32'(dac_gain[c*16 +: 16]), 32'(m_gain[c]));
            check(dac_offset[c*16 +: 16] == m_offs[c], $sformatf("%s/R2 offset ch%0d", req, c),
                  32'(dac_offset[c*16 +: 16]), 32'(m_offs[c]));
            check(dac_ctrl[c*9 +: 9] == m_ctrl[c], $sformatf("%s/R3 dac ctrl ch%0d", req, c),
                  32'(dac_ctrl[c*9 +: 9]), 32'(m_ctrl[c]));
            check(slew_cfg[c*13 +: 13] == m_slew[c], $sformatf("%s/R3 slew ch%0d", req, c),
                  32'(slew_cfg[c*13 +: 13]), 32'(m_slew[c]));
        end
        check(main_cfg == m_main, {req, "/R3 main"}, 32'(main_cfg), 32'(m_main));
        check(dcdc_cfg == m_dcdc, {req, "/R3 dcdc"}, 32'(dcdc_cfg), 32'(m_dcdc));
        check(!miso_oe && !miso, {req, "/R8 idle miso"}, {30'h0, miso_oe, miso}, 32'h0);
    endtask

    task automatic do_frame(input logic [23:0] tx, input int nbits, input string req);
        logic [23:0] rx, exp_rx;
        exp_rx = m_pend ? {8'h0, m_buf} : 24'h0;
        m_pend = 1'b0;
        spi_frame(tx, nbits, rx);
        if (nbits == 24) begin
            check(rx == exp_rx, {req, "/R6 reply"}, 32'(rx), 32'(exp_rx));
            if (tx[23]) begin
                m_buf  = model_read(tx[20:16]);
                m_pend = 1'b1;
            end else begin
                model_write(tx[20:16], tx[15:0]);
            end
        end
        check_state(req);
    endtask

    // Read a register and collect its reply with a no-op frame
    task automatic read_reg(input logic [4:0] a, input logic [15:0] exp, input string req);
        logic [23:0] rx;
        do_frame(mk(1'b1, a, 16'h0), 24, req);
        m_pend = 1'b0;
        spi_frame(24'h1CE000, 24, rx);
        check(rx == {8'h0, exp}, {req, " readback"}, 32'(rx), 32'(exp));
        check_state({req, "/R7 after noop"});
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] rx;
        void'($urandom(32'h1DAC_5EED));
        model_reset();
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);

        // R9: reset values at the ports
        check(dac_gain == {NCH{16'hFFFF}}, "R9 gain reset", dac_gain[31:0], 32'hFFFFFFFF);
        check(dac_offset == {NCH{16'h8000}}, "R9 offset reset", dac_offset[31:0], 32'h80008000);
        check_state("R9");

        // R1, R2: plain writes
        do_frame(mk(1'b0, 5'h02, 16'hA5C3), 24, "R1 code write");
        do_frame(mk(1'b0, 5'h09, 16'h1234), 24, "R2 gain write");
        do_frame(mk(1'b0, 5'h13, 16'h0F0F), 24, "R2 offset write");

        // R3, R4: control sub-registers
        do_frame(mk(1'b0, 5'h1C, {3'd2, 13'h1FC5}), 24, "R4 dac ctrl ch0");
        check(dac_ctrl[6] == 1'b1, "R4 output enable bit", 32'(dac_ctrl[6]), 32'h1);
        do_frame(mk(1'b0, 5'h1E, {3'd3, 13'h1F5A}), 24, "R4 dcdc via ch2");
        do_frame(mk(1'b0, 5'h1D, {3'd1, 13'h0ABC}), 24, "R3 main");
        do_frame(mk(1'b0, 5'h1F, {3'd0, 13'h1357}), 24, "R3 slew ch3");
        do_frame(mk(1'b0, 5'h1F, {3'd4, 13'h1FFF}), 24, "R3 soft sub ignored");
        do_frame(mk(1'b0, 5'h1D, {3'd6, 13'h1FFF}), 24, "R3 sub6 ignored");

        // R5, R6: reads
        read_reg(5'h02, 16'hA5C3, "R5 read code");
        read_reg(5'h18, 16'h0001, "R5 read status");
        read_reg(5'h1A, 16'h005A, "R5 read dcdc");
        read_reg(5'h11, 16'h0000, "R5 read clear");
        read_reg(5'h1B, 16'h0000, "R5 read unmapped");

        // R7 and R10
        do_frame(24'h1CE000, 24, "R7 noop");
        do_frame(mk(1'b0, 5'h05, 16'hFFFF), 24, "R10 unmapped 0x05");
        do_frame(mk(1'b0, 5'h18, 16'hFFFF), 24, "R10 unmapped 0x18");

        // R6: back-to-back reads chain their replies
        do_frame(mk(1'b1, 5'h09, 16'h0), 24, "R6 chain a");
        do_frame(mk(1'b1, 5'h13, 16'h0), 24, "R6 chain b");
        do_frame(mk(1'b0, 5'h00, 16'h7777), 24, "R6 chain c");

        // R11: aborted frames write nothing and consume the pending reply
        do_frame(mk(1'b0, 5'h01, 16'hDEAD), 23, "R11 short write");
        do_frame(mk(1'b0, 5'h01, 16'hBEEF), 25, "R11 long write");
        do_frame(mk(1'b1, 5'h00, 16'h0), 24, "R11 read before abort");
        do_frame(24'h0, 8, "R11 abort eats reply");
        do_frame(24'h1CE000, 24, "R11 no stale reply");

        // Random mix
        for (int n = 0; n < N_RAND; n++) begin
            int op;
            logic [1:0] ch;
            ch = 2'($urandom);
            op = int'($urandom_range(0, 8));
            case (op)
                0: do_frame(mk(1'b0, {3'b000, ch}, 16'($urandom)), 24, "R2 rnd code");
                1: do_frame(mk(1'b0, {3'b010, ch}, 16'($urandom)), 24, "R2 rnd gain");
                2: do_frame(mk(1'b0, {3'b100, ch}, 16'($urandom)), 24, "R2 rnd offset");
                3, 4: do_frame(mk(1'b0, {3'b111, ch}, 16'($urandom)), 24, "R3 rnd ctrl");
                5, 6: do_frame(mk(1'b1, 5'($urandom), 16'($urandom)), 24, "R5 rnd read");
                7: begin
                    if ($urandom_range(0, 1) == 0)
                        do_frame(24'h1CE000, 24, "R7 rnd noop");
                    else
                        do_frame(mk(1'b0, 5'($urandom), 16'($urandom)), 24, "R10 rnd any write");
                end
                default: begin
                    int nb;
                    nb = ($urandom_range(0, 1) == 0) ? int'($urandom_range(1, 23)) : int'($urandom_range(25, 28));
                    do_frame(mk(1'($urandom), 5'($urandom), 16'($urandom)), nb, "R11 rnd abort");
                end
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule